// File: doc/BRIEF.md
# Packet Header Deframer

This block sits on a 64-bit AXI-Stream carrying framed packets and hands only the payload to a downstream consumer. Each packet opens with a 64-bit header word. A flag in that header says whether the next word is a 64-bit timestamp. The block removes the header and, when present, the timestamp, then forwards the remaining words. Payload leaves on a stream whose element width is set by a parameter, either 32 or 64 bits.

Every payload beat carries a 128-bit sideband. The captured header sits in the upper half and the timestamp in the lower half. The sideband does not change across the beats of one packet. Output tlast marks the final element of each packet. In 32-bit mode the byte-length field of the header decides whether the final input word holds one element or two. Everything runs on one clock with a synchronous active-high reset.

Top module: `pkt_deframer`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: The first input word of each packet is the header and is never emitted as payload. When header bit 61 is 0, payload begins with the second word.
- R3: When header bit 61 is 1, the second word is captured as the timestamp and is not emitted as payload. Payload begins with the third word.
- R4: `out_user[127:64]` equals the packet's header word on every beat, and `out_user` stays unchanged across all beats of one packet.
- R5: When header bit 61 is 0, `out_user[63:0]` is zero. Otherwise it equals the captured timestamp word.
- R6: With a 32-bit element width, each 64-bit payload word is emitted as two elements, bits 63:32 first and bits 31:0 second.
- R7: With a 32-bit element width, when bit 2 of the byte-length field (header bit 34) is 1, the packet's last input word yields only its upper element, and that element carries tlast.
- R8: `out_last` is 1 only on the final element of a packet, which comes from the input word that carried `in_last`.
- R9: A packet that ends on its header word, or on its timestamp word, produces no output beat.
- R10: No payload element is dropped or repeated under any pattern of input gaps and output stalls. `in_ready` is 0 only while an output element is waiting and cannot leave in that cycle.
- R11: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data`, `out_user` and `out_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 64 | Input stream word |
| in_last | input | 1 | Last word of the input packet |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block accepts the input word |
| out_data | output | DATA_W | Payload element |
| out_user | output | 128 | Sideband holding the header (127:64) and the timestamp (63:0) |
| out_last | output | 1 | Final element of the packet |
| out_valid | output | 1 | Output element valid |
| out_ready | input | 1 | Consumer accepts the element |

## Verification
A parse state that has slipped by one word shows up on the first beat of the next packet. Either the header or the timestamp word appears in `out_data`, or the sideband carries a payload word. A wrong element count in the output register shows up within one packet. It appears as a missing or extra element, or as tlast on the wrong element, and the bench sees it when it compares each beat with its expected queue. A lost word under stalls leaves the expected queue non-empty once the stream has drained, and a final count check catches this.

// File: rtl/defr_pkg.sv
package defr_pkg;
  localparam int WORD_W    = 64;
  localparam int SIDE_W    = 128;
  localparam int TS_BIT    = 61;
  localparam int LEN_LSB   = 32;

  typedef enum logic [1:0] {
    ST_HDR = 2'd0,
    ST_TS  = 2'd1,
    ST_PAY = 2'd2
  } walk_st_e;

  // odd number of 4-byte elements: header and timestamp are multiples of 8 bytes
  function automatic logic odd_elems(input logic [WORD_W-1:0] hdr);
    return hdr[LEN_LSB+2];
  endfunction
endpackage

// File: rtl/hdr_walker.sv
module hdr_walker
  import defr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_last,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              pay_valid,
  output logic [WORD_W-1:0] pay_word,
  output logic              pay_last,
  output logic              pay_odd,
  output logic [SIDE_W-1:0] pay_side,
  input  logic              stage_ready
);
  walk_st_e          st_q;
  logic [WORD_W-1:0] hdr_q;
  logic [WORD_W-1:0] ts_q;
  logic              in_fire;

  assign in_ready  = (st_q != ST_PAY) || stage_ready;
  assign in_fire   = in_valid && in_ready;
  assign pay_valid = in_valid && (st_q == ST_PAY);
  assign pay_word  = in_data;
  assign pay_last  = in_last;
  assign pay_odd   = odd_elems(hdr_q);
  assign pay_side  = {hdr_q, ts_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_HDR;
      hdr_q <= '0;
      ts_q  <= '0;
    end else if (in_fire) begin
      unique case (st_q)
        ST_HDR: begin
          hdr_q <= in_data;
          ts_q  <= '0;
          if (in_last)             st_q <= ST_HDR;
          else if (in_data[TS_BIT]) st_q <= ST_TS;
          else                     st_q <= ST_PAY;
        end
        ST_TS: begin
          ts_q <= in_data;
          st_q <= in_last ? ST_HDR : ST_PAY;
        end
        default: begin
          if (in_last) st_q <= ST_HDR;
        end
      endcase
    end
  end

  // R3
  ts_state_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_TS) |-> hdr_q[TS_BIT]);

  // R5
  ts_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PAY && !hdr_q[TS_BIT]) |-> (ts_q == '0));
endmodule

// File: rtl/beat_stage.sv
module beat_stage
  import defr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_valid,
  input  logic [WORD_W-1:0] take_word,
  input  logic              take_last,
  input  logic              take_odd,
  input  logic [SIDE_W-1:0] take_side,
  output logic              take_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [SIDE_W-1:0] out_user,
  output logic              out_last,
  output logic              out_valid,
  input  logic              out_ready
);
  localparam int EPW = WORD_W / DATA_W;

  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] word_shift;
  logic [SIDE_W-1:0] side_q;
  logic              last_q;
  logic [1:0]        cnt_q;
  logic              full_q;
  logic              drain_last;
  logic              take;
  logic [1:0]        load_cnt;

  generate
    if (EPW == 2) begin : g_split
      assign word_shift = {word_q[DATA_W-1:0], {DATA_W{1'b0}}};
      assign load_cnt   = (take_last && take_odd) ? 2'd1 : 2'd2;
    end else begin : g_pass
      assign word_shift = word_q;
      assign load_cnt   = 2'd1;
    end
  endgenerate

  assign drain_last = full_q && out_ready && (cnt_q == 2'd1);
  assign take_ready = !full_q || drain_last;
  assign take       = take_valid && take_ready;

  assign out_valid = full_q;
  assign out_data  = word_q[WORD_W-1 -: DATA_W];
  assign out_user  = side_q;
  assign out_last  = last_q && (cnt_q == 2'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      cnt_q  <= 2'd0;
      word_q <= '0;
      side_q <= '0;
      last_q <= 1'b0;
    end else if (take) begin
      full_q <= 1'b1;
      word_q <= take_word;
      side_q <= take_side;
      last_q <= take_last;
      cnt_q  <= load_cnt;
    end else if (full_q && out_ready) begin
      if (cnt_q == 2'd1) begin
        full_q <= 1'b0;
        cnt_q  <= 2'd0;
      end else begin
        cnt_q  <= cnt_q - 2'd1;
        word_q <= word_shift;
      end
    end
  end

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                   $stable(out_user) && $stable(out_last)));

  // R4
  user_const_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !out_last) |=> (out_user == $past(out_user)));

  // R10
  keep_chk: assert property (@(posedge clk) disable iff (rst)
    (full_q && !out_ready) |=> full_q);

  // R7
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    full_q |-> (cnt_q != 2'd0 && cnt_q <= 2'(EPW)));
endmodule

// File: rtl/pkt_deframer.sv
module pkt_deframer
  import defr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [63:0]       in_data,
  input  logic              in_last,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [127:0]      out_user,
  output logic              out_last,
  output logic              out_valid,
  input  logic              out_ready
);
  logic              pay_valid;
  logic [WORD_W-1:0] pay_word;
  logic              pay_last;
  logic              pay_odd;
  logic [SIDE_W-1:0] pay_side;
  logic              stage_ready;

  hdr_walker u_walk (
    .clk        (clk),
    .rst        (rst),
    .in_data    (in_data),
    .in_last    (in_last),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .pay_valid  (pay_valid),
    .pay_word   (pay_word),
    .pay_last   (pay_last),
    .pay_odd    (pay_odd),
    .pay_side   (pay_side),
    .stage_ready(stage_ready)
  );

  beat_stage #(.DATA_W(DATA_W)) u_stage (
    .clk       (clk),
    .rst       (rst),
    .take_valid(pay_valid),
    .take_word (pay_word),
    .take_last (pay_last),
    .take_odd  (pay_odd),
    .take_side (pay_side),
    .take_ready(stage_ready),
    .out_data  (out_data),
    .out_user  (out_user),
    .out_last  (out_last),
    .out_valid (out_valid),
    .out_ready (out_ready)
  );
endmodule

// File: tb/tb_pkt_deframer.sv
module tb_pkt_deframer;
  localparam int CLK_P = 10;
  localparam int NPKT  = 10;
  // entry: [15] timestamp, [14] odd tail, [13] stalls, [11:8] payload words, [7:0] expected elements
  localparam logic [15:0] TBL [NPKT] = '{
    16'h0102, 16'h8204, 16'h4305, 16'hC101, 16'h0000,
    16'h8000, 16'h2408, 16'hE509, 16'h6101, 16'hA306
  };

  logic clk = 0, rst = 1;
  logic [63:0] in_data = '0;
  logic in_last = 0, in_valid = 0, in_ready;
  logic [31:0] out_data;
  logic [127:0] out_user;
  logic out_last, out_valid, out_ready = 0;

  int checks = 0, fails = 0;
  logic [31:0]  exp_data [256];
  logic [127:0] exp_user [256];
  logic         exp_last [256];
  int wr_idx = 0, rd_idx = 0;
  logic stall_en = 0, hold = 0, done = 0;
  logic [15:0] lfsr = 16'hACE1;

  pkt_deframer dut (.*);

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = hold ? 1'b0 : (stall_en ? (lfsr[0] | lfsr[5]) : 1'b1);
  end

  function automatic logic [31:0] elem(input int p, input int w, input logic hi);
    return hi ? {p[7:0], w[7:0], 16'hC0DE} : {p[7:0], w[7:0], 16'hBEEF};
  endfunction

  task automatic push(input logic [63:0] d, input logic l);
    @(negedge clk);
    if (stall_en && lfsr[2]) @(negedge clk);
    in_valid = 1; in_data = d; in_last = l;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 0;
  endtask

  task automatic send_pkt(input int p, input logic ts, input int nw, input logic odd);
    int elems;
    logic [63:0] hdr, tsv;
    logic [127:0] usr;
    elems = (nw > 0) ? 2*nw - (odd ? 1 : 0) : 0;
    hdr = {2'(p), ts, 1'b0, 12'(p), 16'(8 + (ts ? 8 : 0) + 4*elems), 16'h5A00 + 16'(p), 16'h00C3};
    tsv = {32'h7100_0000 + 32'(p), 32'h0BAD_F00D};
    usr = {hdr, ts ? tsv : 64'h0};
    for (int w = 0; w < nw; w++) begin
      logic tail;
      tail = (w == nw-1);
      exp_data[wr_idx] = elem(p, w, 1'b1); exp_user[wr_idx] = usr;
      exp_last[wr_idx] = tail && odd; wr_idx++;
      if (!(tail && odd)) begin
        exp_data[wr_idx] = elem(p, w, 1'b0); exp_user[wr_idx] = usr;
        exp_last[wr_idx] = tail; wr_idx++;
      end
    end
    push(hdr, (nw == 0) && !ts);
    if (ts) push(tsv, nw == 0);
    for (int w = 0; w < nw; w++) push({elem(p, w, 1'b1), elem(p, w, 1'b0)}, w == nw-1);
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid && out_ready) begin
        if (rd_idx >= wr_idx) begin
          fails++; checks++;
          $display("FAIL R10 extra beat: got %h expected none", out_data);
        end else begin
          checks += 3;
          if (out_data !== exp_data[rd_idx]) begin
            fails++; $display("FAIL R2/R3/R6 data[%0d]: got %h expected %h", rd_idx, out_data, exp_data[rd_idx]);
          end
          if (out_last !== exp_last[rd_idx]) begin
            fails++; $display("FAIL R7/R8 last[%0d]: got %b expected %b", rd_idx, out_last, exp_last[rd_idx]);
          end
          if (out_user !== exp_user[rd_idx]) begin
            fails++; $display("FAIL R4/R5 user[%0d]: got %h expected %h", rd_idx, out_user, exp_user[rd_idx]);
          end
          rd_idx++;
        end
      end
      if (!in_ready) begin
        checks++;
        if (!out_valid) begin
          fails++; $display("FAIL R10 in_ready low: got out_valid=%b expected 1", out_valid);
        end
      end
    end
  end

  task automatic chk(input logic ok, input string what, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++; $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got hang expected completion");
    summary();
  end

  initial begin
    int exp_sum;
    logic [31:0] d0;
    exp_sum = 0;
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && in_ready == 1, "R1 in reset", {out_valid, in_ready}, 64'h1);
    rst = 0;
    @(negedge clk);
    chk(out_valid == 0 && in_ready == 1, "R1 after reset", {out_valid, in_ready}, 64'h1);

    // table walk
    for (int i = 0; i < NPKT; i++) begin
      stall_en = TBL[i][13];
      send_pkt(i, TBL[i][15], int'(TBL[i][11:8]), TBL[i][14]);
      exp_sum += int'(TBL[i][7:0]);
    end
    while (rd_idx < wr_idx) @(negedge clk);
    stall_en = 0;
    chk(rd_idx == exp_sum, "R10 element count", 64'(rd_idx), 64'(exp_sum));

    // R9: header-only packet yields nothing
    repeat (4) @(negedge clk);
    send_pkt(30, 1'b0, 0, 1'b0);
    send_pkt(31, 1'b1, 0, 1'b0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(out_valid == 0, "R9 no output", 64'(out_valid), 64'h0);
    end

    // R11 / R10: blocked output
    hold = 1;
    fork
      send_pkt(40, 1'b1, 2, 1'b0);
    join_none
    repeat (10) @(negedge clk);
    d0 = out_data;
    chk(out_valid == 1, "R11 valid held", 64'(out_valid), 64'h1);
    chk(out_data == elem(40, 0, 1'b1), "R6 first element upper", 64'(out_data), 64'(elem(40, 0, 1'b1)));
    chk(in_ready == 0, "R10 backpressure", 64'(in_ready), 64'h0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(out_data == d0 && out_valid, "R11 data stable", 64'(out_data), 64'(d0));
    end
    hold = 0;
    while (rd_idx < wr_idx) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(rd_idx == wr_idx && !out_valid, "R10 drained", 64'(rd_idx), 64'(wr_idx));
    summary();
  end
endmodule